// File: doc/BRIEF.md
# Tap-Difference Timing Error Detector and Loop Filter

This block closes the timing loop of a receiver whose clock recovery and fractionally spaced equalizer are adapted together. On each symbol strobe it reads two adaptive equalizer weights: the one just ahead of the center tap and the one just behind it. When sampling is on time the two weights are balanced. Late sampling moves energy to the later tap and early sampling moves it to the earlier one. The difference between the two weights is therefore a signed timing error. It is formed with one subtraction and no multiplier.

The error drives a proportional-plus-integral loop filter. Each gain is a programmable arithmetic right shift. The filter removes symbol-to-symbol jitter and keeps the steady part of the error. Its registered output is the control word for the numerically controlled oscillator that steers the interpolator. The integrator and the output both saturate at their signed limits and never wrap. When the loop is disabled, the integrator and the output are forced to zero.

Top module: `tapdiff_timing_loop`

## Requirements
- R1: On a strobe with the loop enabled, the timing error is the earlier-side weight `w_pre` minus the later-side weight `w_post`, taken as signed values without loss of width.
- R2: Starting from a cleared integrator, an error with `w_pre > w_post` (early sampling) gives `ctrl_o >= 0`, and an error with `w_post > w_pre` (late sampling) gives `ctrl_o <= 0`.
- R3: The size of the correction follows the size of the error. With a proportional shift of 0, a strobe from a cleared state with a large integral shift gives a control word equal to the error.
- R4: The integrator adds `err >>> ki_shift` on every enabled strobe. The control word is the new integrator value plus `err >>> kp_shift`.
- R5: The integrator saturates at +(2^(INT_W-1)-1) and -(2^(INT_W-1)) and never wraps.
- R6: The sum of the integrator and the proportional term saturates to the OUT_W signed range before it is driven on `ctrl_o`.
- R7: While `loop_en` is low, the integrator and `ctrl_o` are cleared to 0 at the next clock edge, and both are 0 during reset. After the loop is re-enabled, accumulation starts again from zero.
- R8: With `loop_en` high and `sym_stb` low, `ctrl_o` and the integrator hold their values whatever the weight inputs do.
- R9: `ctrl_o` changes only at the clock edge that samples the strobe. Before that edge it still shows the previous value.
- R10: Both gain shifts are arithmetic, so a negative term rounds toward minus infinity. For example, an error of -3 with a shift of 1 contributes -2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| loop_en | input | 1 | Loop enable; low clears the integrator and the output |
| sym_stb | input | 1 | One update per cycle in which this is high |
| kp_shift | input | SH_W | Right-shift amount for the proportional path |
| ki_shift | input | SH_W | Right-shift amount for the integral path |
| w_pre | input | W | Signed weight of the tap before the center tap |
| w_post | input | W | Signed weight of the tap after the center tap |
| ctrl_o | output | OUT_W | Signed, registered oscillator control word |

## Verification
The bench builds the block with 12-bit weights, a 16-bit integrator, a 16-bit output and 4-bit shift amounts. A full-scale error of 4095 with an integral shift of 0 saturates the integrator after nine strobes. Because the integrator and the output have the same width, adding a proportional term to a saturated integrator exercises the output clamp on its own, in both signs. A shift range of 0 to 15 covers the case where a term shifts down to 0 or to -1, so the floor rounding of negative errors is observable at the port.

// File: rtl/tdl_pkg.sv
package tdl_pkg;
  // Per-cycle action of the loop state registers.
  typedef enum logic [1:0] {
    LM_IDLE   = 2'd0,  // loop disabled: clear state
    LM_HOLD   = 2'd1,  // enabled, no strobe: keep state
    LM_UPDATE = 2'd2   // enabled with strobe: take new value
  } loop_mode_e;
endpackage

// File: rtl/tdl_errdet.sv
module tdl_errdet #(
  parameter int W = 16
) (
  input  logic signed [W-1:0] w_pre,
  input  logic signed [W-1:0] w_post,
  output logic signed [W:0]   err
);
  // One subtraction, widened by one bit so no difference overflows.
  always_comb begin
    err = $signed({w_pre[W-1], w_pre}) - $signed({w_post[W-1], w_post});
  end
endmodule

// File: rtl/tdl_integ.sv
module tdl_integ
  import tdl_pkg::*;
#(
  parameter int W     = 16,
  parameter int INT_W = 24,
  parameter int SH_W  = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  loop_mode_e              mode,
  input  logic signed [W:0]       err,
  input  logic        [SH_W-1:0]  ki_shift,
  output logic signed [INT_W-1:0] integ_sat,
  output logic signed [INT_W-1:0] integ_q
);
  localparam int SW = INT_W + 1;
  localparam logic signed [INT_W-1:0] IMAX = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic signed [INT_W-1:0] IMIN = {1'b1, {(INT_W-1){1'b0}}};

  logic signed [SW-1:0]    err_x;
  logic signed [SW-1:0]    inc;
  logic signed [SW-1:0]    sum;
  logic                    ovf;
  logic signed [INT_W-1:0] integ_nx;

  always_comb begin
    err_x = SW'(err);
    inc   = err_x >>> ki_shift;
    sum   = $signed({integ_q[INT_W-1], integ_q}) + inc;
    ovf   = sum[SW-1] ^ sum[SW-2];
    if (ovf) begin
      integ_sat = sum[SW-1] ? IMIN : IMAX;
    end else begin
      integ_sat = sum[INT_W-1:0];
    end
  end

  always_comb begin
    case (mode)
      LM_UPDATE: integ_nx = integ_sat;
      LM_HOLD:   integ_nx = integ_q;
      default:   integ_nx = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      integ_q <= '0;
    end else begin
      integ_q <= integ_nx;
    end
  end
endmodule

// File: rtl/tdl_outstage.sv
module tdl_outstage
  import tdl_pkg::*;
#(
  parameter int W     = 16,
  parameter int INT_W = 24,
  parameter int OUT_W = 16,
  parameter int SH_W  = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  loop_mode_e              mode,
  input  logic signed [W:0]       err,
  input  logic        [SH_W-1:0]  kp_shift,
  input  logic signed [INT_W-1:0] integ_sat,
  output logic signed [OUT_W-1:0] ctrl_q
);
  localparam int SW = INT_W + 1;
  localparam int TW = INT_W + 2;
  localparam logic signed [TW-1:0] OMAX = {{(TW-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [TW-1:0] OMIN = {{(TW-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  logic signed [SW-1:0]    err_x;
  logic signed [SW-1:0]    prop;
  logic signed [TW-1:0]    total;
  logic signed [TW-1:0]    clamped;
  logic signed [OUT_W-1:0] ctrl_nx;

  always_comb begin
    err_x = SW'(err);
    prop  = err_x >>> kp_shift;
    total = $signed({{2{integ_sat[INT_W-1]}}, integ_sat}) + TW'(prop);
    if (total > OMAX) begin
      clamped = OMAX;
    end else if (total < OMIN) begin
      clamped = OMIN;
    end else begin
      clamped = total;
    end
  end

  always_comb begin
    case (mode)
      LM_UPDATE: ctrl_nx = clamped[OUT_W-1:0];
      LM_HOLD:   ctrl_nx = ctrl_q;
      default:   ctrl_nx = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else begin
      ctrl_q <= ctrl_nx;
    end
  end
endmodule

// File: rtl/tapdiff_timing_loop.sv
module tapdiff_timing_loop
  import tdl_pkg::*;
#(
  parameter int W     = 16,  // equalizer weight width
  parameter int INT_W = 24,  // integrator width, at least W+1
  parameter int OUT_W = 16,  // control word width, at most INT_W+1
  parameter int SH_W  = 5    // width of the gain shift amounts
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    loop_en,
  input  logic                    sym_stb,
  input  logic        [SH_W-1:0]  kp_shift,
  input  logic        [SH_W-1:0]  ki_shift,
  input  logic signed [W-1:0]     w_pre,
  input  logic signed [W-1:0]     w_post,
  output logic signed [OUT_W-1:0] ctrl_o
);
  loop_mode_e              mode;
  logic signed [W:0]       err;
  logic signed [INT_W-1:0] integ_sat;
  logic signed [INT_W-1:0] integ_q;
  logic signed [OUT_W-1:0] ctrl_q;

  always_comb begin
    if (!loop_en) begin
      mode = LM_IDLE;
    end else if (sym_stb) begin
      mode = LM_UPDATE;
    end else begin
      mode = LM_HOLD;
    end
  end

  tdl_errdet #(.W(W)) u_err (
    .w_pre  (w_pre),
    .w_post (w_post),
    .err    (err)
  );

  tdl_integ #(.W(W), .INT_W(INT_W), .SH_W(SH_W)) u_integ (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .err       (err),
    .ki_shift  (ki_shift),
    .integ_sat (integ_sat),
    .integ_q   (integ_q)
  );

  tdl_outstage #(.W(W), .INT_W(INT_W), .OUT_W(OUT_W), .SH_W(SH_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .err       (err),
    .kp_shift  (kp_shift),
    .integ_sat (integ_sat),
    .ctrl_q    (ctrl_q)
  );

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/tapdiff_timing_loop_chk.sv
module tapdiff_timing_loop_chk #(
  parameter int W     = 16,
  parameter int INT_W = 24,
  parameter int OUT_W = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    loop_en,
  input logic                    sym_stb,
  input logic signed [W-1:0]     w_pre,
  input logic signed [W-1:0]     w_post,
  input logic signed [INT_W-1:0] integ_q,
  input logic signed [OUT_W-1:0] ctrl_o
);
  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_en |=> (ctrl_o == '0 && integ_q == '0)); // R7

  AST_HOLD_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_en && !sym_stb) |=> ($stable(ctrl_o) && $stable(integ_q))); // R8

  AST_EARLY_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_en && sym_stb && w_pre > w_post && integ_q >= 0) |=> ctrl_o >= 0); // R2

  AST_LATE_NONPOS: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_en && sym_stb && w_pre < w_post && integ_q <= 0) |=> ctrl_o <= 0); // R2

  AST_INT_NO_WRAP_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_en && sym_stb && w_pre >= w_post && integ_q > 0) |=> integ_q > 0); // R5

  AST_INT_NO_WRAP_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_en && sym_stb && w_pre <= w_post && integ_q < 0) |=> integ_q < 0); // R5
endmodule

bind tapdiff_timing_loop tapdiff_timing_loop_chk #(
  .W(W), .INT_W(INT_W), .OUT_W(OUT_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .loop_en (loop_en),
  .sym_stb (sym_stb),
  .w_pre   (w_pre),
  .w_post  (w_post),
  .integ_q (integ_q),
  .ctrl_o  (ctrl_o)
);

// File: tb/tb_tapdiff_timing_loop.sv
module tb_tapdiff_timing_loop;
  localparam int W     = 12;
  localparam int INT_W = 16;
  localparam int OUT_W = 16;
  localparam int SH_W  = 4;

  logic                    clk;
  logic                    rst_n;
  logic                    loop_en;
  logic                    sym_stb;
  logic        [SH_W-1:0]  kp_shift;
  logic        [SH_W-1:0]  ki_shift;
  logic signed [W-1:0]     w_pre;
  logic signed [W-1:0]     w_post;
  logic signed [OUT_W-1:0] ctrl_o;

  int    n_run;
  int    n_fail;
  longint m_integ;
  longint m_ctrl;

  tapdiff_timing_loop #(.W(W), .INT_W(INT_W), .OUT_W(OUT_W), .SH_W(SH_W)) dut (
    .clk(clk), .rst_n(rst_n), .loop_en(loop_en), .sym_stb(sym_stb),
    .kp_shift(kp_shift), .ki_shift(ki_shift),
    .w_pre(w_pre), .w_post(w_post), .ctrl_o(ctrl_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic longint sat_to(longint v, int bits);
    longint hi;
    longint lo;
    hi = (longint'(1) <<< (bits - 1)) - 1;
    lo = -(longint'(1) <<< (bits - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  task automatic check(string tag, longint act, longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: ctrl actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One clock cycle starting just after a falling edge.
  task automatic cyc(string tag, bit en, bit stb, int pre, int post, int kp, int ki);
    longint e;
    loop_en  = en;
    sym_stb  = stb;
    w_pre    = W'(pre);
    w_post   = W'(post);
    kp_shift = SH_W'(kp);
    ki_shift = SH_W'(ki);
    #1;
    check("R9 before edge", longint'(ctrl_o), m_ctrl);
    @(posedge clk);
    @(negedge clk);
    if (!en) begin
      m_integ = 0;
      m_ctrl  = 0;
    end else if (stb) begin
      e       = longint'(pre) - longint'(post);
      m_integ = sat_to(m_integ + (e >>> ki), INT_W);
      m_ctrl  = sat_to(m_integ + (e >>> kp), OUT_W);
    end
    check(tag, longint'(ctrl_o), m_ctrl);
  endtask

  task automatic clear_loop();
    cyc("R7 clear", 1'b0, 1'b0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    longint first;
    n_run = 0; n_fail = 0; m_integ = 0; m_ctrl = 0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; loop_en = 1'b0; sym_stb = 1'b0;
    kp_shift = '0; ki_shift = '0; w_pre = '0; w_post = '0;
    repeat (3) @(negedge clk);
    check("R7 reset", longint'(ctrl_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R3: pure difference, proportional gain of one
    cyc("R1 difference", 1'b1, 1'b1, 300, 100, 0, 15);
    check("R1 exact", longint'(ctrl_o), 200);
    clear_loop();
    cyc("R3 small error", 1'b1, 1'b1, 10, 5, 0, 15);
    first = longint'(ctrl_o);
    clear_loop();
    cyc("R3 large error", 1'b1, 1'b1, 1000, 5, 0, 15);
    check("R3 larger correction", longint'(longint'(ctrl_o) > first), 1);

    // R2: signs from a cleared state
    clear_loop();
    cyc("R2 early", 1'b1, 1'b1, 700, -200, 2, 3);
    check("R2 early positive", longint'(ctrl_o > 0), 1);
    clear_loop();
    cyc("R2 late", 1'b1, 1'b1, -150, 650, 2, 3);
    check("R2 late negative", longint'(ctrl_o < 0), 1);

    // R10: floor rounding of negative terms
    clear_loop();
    cyc("R10 floor shift", 1'b1, 1'b1, 0, 3, 1, 1);
    check("R10 exact", longint'(ctrl_o), -4);

    // R4: accumulation over several strobes
    clear_loop();
    for (int i = 0; i < 6; i++) cyc("R4 accumulate", 1'b1, 1'b1, 400, 100 + 20 * i, 2, 1);

    // R8: hold without strobe while weights move
    for (int i = 0; i < 5; i++) cyc("R8 hold", 1'b1, 1'b0, 2047 - 300 * i, -2048 + 77 * i, 0, 0);

    // R7: disable then re-enable starts from zero
    clear_loop();
    check("R7 disable", longint'(ctrl_o), 0);
    cyc("R7 restart", 1'b1, 1'b1, 50, 20, 15, 0);
    check("R7 fresh", longint'(ctrl_o), 30);

    // R5: integrator saturation high, then R6 output clamp
    clear_loop();
    for (int i = 0; i < 10; i++) cyc("R5 sat high", 1'b1, 1'b1, 2047, -2048, 15, 0);
    check("R5 integ max", longint'(ctrl_o), 32767);
    cyc("R6 out clamp high", 1'b1, 1'b1, 2047, -2048, 0, 15);
    check("R6 max", longint'(ctrl_o), 32767);
    clear_loop();
    for (int i = 0; i < 10; i++) cyc("R5 sat low", 1'b1, 1'b1, -2048, 2047, 15, 0);
    check("R5 integ min", longint'(ctrl_o), -32768);
    cyc("R6 out clamp low", 1'b1, 1'b1, -2048, 2047, 0, 15);
    check("R6 min", longint'(ctrl_o), -32768);

    // Random mix covering R1 R4 R5 R6 R7 R8 R10
    clear_loop();
    for (int i = 0; i < 400; i++) begin
      bit en;
      bit stb;
      en  = ($urandom_range(0, 19) != 0);
      stb = ($urandom_range(0, 1) == 1);
      cyc("R4 random", en, stb,
          int'($urandom_range(0, 4095)) - 2048, int'($urandom_range(0, 4095)) - 2048,
          int'($urandom_range(0, 15)), int'($urandom_range(0, 15)));
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule